// File: doc/BRIEF.md
# Connected Component First-Pass Labeler

This block is the first stage of a two-pass connected component labeler for binary images. It takes a raster-scan stream of one-bit pixels, one pixel per clock, and gives every foreground pixel a provisional label. It looks only at the pixel directly above and the pixel directly to the left, so it needs a single line of stored labels from the previous row.

While scanning, it creates fresh labels, passes existing labels on to connected pixels, and emits a stream of label-pair writes. Each write states that two provisional labels belong to the same blob. A later stage resolves these pairs, holds the frame and relabels it. That later stage is not part of this block.

An optional mode tags every blob that touches the top, left or right edge with a reserved all-ones label, so such blobs can be discarded. At the last pixel of a frame the block reports how many labels and pairs it used, and whether a limit was hit.

Top module: `cc_first_pass`

## Requirements
- R1: A background pixel (`pixData` = 0) produces label 0 and no pair write.
- R2: A foreground pixel whose upper and left neighbours are both label 0 gets a new label. Neighbours outside the image (first row, first column) count as label 0. Within a frame, new labels are handed out as 1, 2, 3, … in scan order.
- R3: A foreground pixel with exactly one non-zero neighbour takes that label. If both neighbours carry the same non-zero label, it takes that label.
- R4: A foreground pixel whose two neighbours carry different non-zero labels takes the smaller one. It also raises `eqValid` with `eqLo` = smaller, `eqHi` = larger and `eqBorder` = 0.
- R5: A pair write whose (`eqLo`, `eqHi`, `eqBorder`) equals the last pair written in the same frame is suppressed.
- R6: Once `MAX_LABELS` labels are in use, a pixel that needs a new label gets label `MAX_LABELS`, the label count does not grow, and `frameOverflow` is set.
- R7: Once `MAX_EQUIV` pairs have been written in a frame, further pairs are dropped and `frameOverflow` is set.
- R8: A pixel flagged `pixSof` starts a new frame. The label count, the pair count, the overflow flag and the duplicate memory all restart from zero at that pixel.
- R9: `doneValid` pulses for one cycle, together with the output of the pixel flagged `pixEof`. At that moment `labelsUsed`, `equivsUsed` and `frameOverflow` hold that frame's totals.
- R10: With `borderEn` = 1, a foreground pixel in the first row, the first column or an end-of-row column gets label 255. So does a foreground pixel with a neighbour labelled 255. If such a pixel has any neighbours with non-zero labels other than 255, it writes a pair with `eqBorder` = 1: `eqLo`/`eqHi` are the smaller and larger of those labels, or the same label twice if there is only one. With `borderEn` = 0, label 255 is never produced.
- R11: Each input pixel yields its output exactly one cycle later. `outValid` follows `pixValid` with one cycle of delay, and idle cycles produce no output.
- R12: After reset, `outValid`, `eqValid`, `doneValid`, `labelsUsed`, `equivsUsed` and `frameOverflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| borderEn | input | 1 | Tag edge-touching blobs with label 255 |
| pixValid | input | 1 | Input pixel present this cycle |
| pixData | input | 1 | Pixel value, 1 = foreground |
| pixSof | input | 1 | First pixel of a frame |
| pixEol | input | 1 | Last pixel of a row |
| pixEof | input | 1 | Last pixel of a frame |
| outValid | output | 1 | Output label valid |
| outLabel | output | 8 | Provisional label of the pixel |
| eqValid | output | 1 | Pair write strobe |
| eqLo | output | 8 | Smaller label of the pair |
| eqHi | output | 8 | Larger label of the pair |
| eqBorder | output | 1 | Pair class touches the image edge |
| doneValid | output | 1 | End-of-frame report pulse |
| labelsUsed | output | 8 | Labels allocated in the frame |
| equivsUsed | output | EQ_W | Pairs written in the frame |
| frameOverflow | output | 1 | A label or pair limit was exceeded in the frame |

## Verification
The assertions assume frames arrive whole. Every frame starts with a `pixSof` pixel, every row has the same width and ends with `pixEol`, and `borderEn` stays constant within a frame. The duplicate and done checks depend on this framing. The stimulus keeps to it: it builds rectangular images, marks the first and last pixels and each row end, and changes `borderEn` only between frames. Idle cycles are inserted both inside and between frames, which exercises the valid-gating assumptions without breaking row structure.

// File: rtl/ccl_pkg.sv
package ccl_pkg;
  localparam int LBL_W = 8;
  localparam logic [LBL_W-1:0] BORDER_LBL = '1;

  // control -> datapath strobes
  typedef struct packed {
    logic             firstRow;
    logic             colZero;
    logic [LBL_W-1:0] newLabel;
    logic             eqGrant;
  } ctrl2dp_t;

  // datapath -> control requests
  typedef struct packed {
    logic             wantNew;
    logic             wantEq;
    logic [LBL_W-1:0] eqLo;
    logic [LBL_W-1:0] eqHi;
    logic             eqBorder;
  } dp2ctrl_t;
endpackage

// File: rtl/ccl_line_buf.sv
module ccl_line_buf #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wrEn,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] mem [DEPTH];

  // read returns the entry stored during the previous row
  assign rdData = mem[addr];

  always_ff @(posedge clk) begin
    if (wrEn) mem[addr] <= wrData;
  end
endmodule

// File: rtl/ccl_ctrl.sv
module ccl_ctrl
  import ccl_pkg::*;
#(
  parameter int MAX_COLS   = 512,
  parameter int MAX_LABELS = 254,
  parameter int MAX_EQUIV  = 512,
  localparam int COL_W = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1,
  localparam int EQ_W  = $clog2(MAX_EQUIV + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixValid,
  input  logic             pixSof,
  input  logic             pixEol,
  input  logic             pixEof,
  input  dp2ctrl_t         req,
  output ctrl2dp_t         strobe,
  output logic [COL_W-1:0] col,
  output logic             doneValid,
  output logic [LBL_W-1:0] labelsUsed,
  output logic [EQ_W-1:0]  equivsUsed,
  output logic             frameOverflow
);
  localparam logic [LBL_W-1:0] LBL_LIMIT = LBL_W'(MAX_LABELS);
  localparam logic [EQ_W-1:0]  EQ_LIMIT  = EQ_W'(MAX_EQUIV);

  logic [COL_W-1:0] colReg;
  logic             firstRowReg;
  logic [LBL_W-1:0] labelCnt;
  logic [EQ_W-1:0]  eqCnt;
  logic             ovfReg;
  logic             lastValid;
  logic [LBL_W-1:0] lastLo, lastHi;
  logic             lastBorder;
  logic             doneReg;

  logic             sofNow;
  logic [LBL_W-1:0] cntBase;
  logic [EQ_W-1:0]  eqBase;
  logic             ovfBase;
  logic             lastValidBase;
  logic             labelFull, eqFull;
  logic             dupPair;
  logic             labelOvfNow, eqOvfNow;
  logic             grant;

  always_comb begin
    sofNow        = pixValid & pixSof;
    cntBase       = sofNow ? '0 : labelCnt;
    eqBase        = sofNow ? '0 : eqCnt;
    ovfBase       = sofNow ? 1'b0 : ovfReg;
    lastValidBase = sofNow ? 1'b0 : lastValid;
    labelFull     = (cntBase >= LBL_LIMIT);
    eqFull        = (eqBase >= EQ_LIMIT);
    dupPair       = lastValidBase && (req.eqLo == lastLo) && (req.eqHi == lastHi)
                    && (req.eqBorder == lastBorder);
    labelOvfNow   = req.wantNew & labelFull;
    grant         = req.wantEq & ~dupPair & ~eqFull;
    eqOvfNow      = req.wantEq & ~dupPair & eqFull;

    strobe.firstRow = sofNow | firstRowReg;
    strobe.colZero  = sofNow | (colReg == '0);
    strobe.newLabel = labelFull ? LBL_LIMIT : cntBase + 1'b1;
    strobe.eqGrant  = grant;
    col             = sofNow ? '0 : colReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colReg      <= '0;
      firstRowReg <= 1'b1;
      labelCnt    <= '0;
      eqCnt       <= '0;
      ovfReg      <= 1'b0;
      lastValid   <= 1'b0;
      lastLo      <= '0;
      lastHi      <= '0;
      lastBorder  <= 1'b0;
      doneReg     <= 1'b0;
    end else begin
      doneReg <= pixValid & pixEof;
      if (pixValid) begin
        colReg      <= pixEol ? '0 : col + 1'b1;
        firstRowReg <= pixEol ? 1'b0 : strobe.firstRow;
        labelCnt    <= cntBase + ((req.wantNew && !labelFull) ? LBL_W'(1) : LBL_W'(0));
        eqCnt       <= eqBase + (grant ? EQ_W'(1) : EQ_W'(0));
        ovfReg      <= ovfBase | labelOvfNow | eqOvfNow;
        lastValid   <= lastValidBase | grant;
        if (grant) begin
          lastLo     <= req.eqLo;
          lastHi     <= req.eqHi;
          lastBorder <= req.eqBorder;
        end
      end
    end
  end

  assign doneValid     = doneReg;
  assign labelsUsed    = labelCnt;
  assign equivsUsed    = eqCnt;
  assign frameOverflow = ovfReg;
endmodule

// File: rtl/ccl_datapath.sv
module ccl_datapath
  import ccl_pkg::*;
#(
  parameter int MAX_COLS = 512,
  localparam int COL_W = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             borderEn,
  input  logic             pixValid,
  input  logic             pixData,
  input  logic             pixEol,
  input  logic [COL_W-1:0] col,
  input  ctrl2dp_t         strobe,
  output dp2ctrl_t         req,
  output logic             outValid,
  output logic [LBL_W-1:0] outLabel,
  output logic             eqValid,
  output logic [LBL_W-1:0] eqLo,
  output logic [LBL_W-1:0] eqHi,
  output logic             eqBorder
);
  logic [LBL_W-1:0] rowAbove;
  logic [LBL_W-1:0] leftReg;
  logic [LBL_W-1:0] topL, leftL;
  logic             topHas, leftHas, topPlain, leftPlain;
  logic             borderHit;
  logic [LBL_W-1:0] minL, maxL, plainLo, plainHi;
  logic [LBL_W-1:0] decided;

  ccl_line_buf #(.DEPTH(MAX_COLS), .WIDTH(LBL_W)) u_lineBuf (
    .clk    (clk),
    .wrEn   (pixValid),
    .addr   (col),
    .wrData (decided),
    .rdData (rowAbove)
  );

  always_comb begin
    topL      = strobe.firstRow ? '0 : rowAbove;
    leftL     = strobe.colZero ? '0 : leftReg;
    topHas    = (topL != '0);
    leftHas   = (leftL != '0);
    topPlain  = topHas & (topL != BORDER_LBL);
    leftPlain = leftHas & (leftL != BORDER_LBL);
    borderHit = borderEn & pixData & (strobe.firstRow | strobe.colZero | pixEol
                | (topL == BORDER_LBL) | (leftL == BORDER_LBL));
    minL      = (topL < leftL) ? topL : leftL;
    maxL      = (topL < leftL) ? leftL : topL;

    // pair among the ordinary neighbour labels
    if (topPlain && leftPlain) begin
      plainLo = minL;
      plainHi = maxL;
    end else begin
      plainLo = topPlain ? topL : leftL;
      plainHi = plainLo;
    end

    req = '0;
    if (!pixData) begin
      decided = '0;
    end else if (borderHit) begin
      decided      = BORDER_LBL;
      req.wantEq   = pixValid & (topPlain | leftPlain);
      req.eqLo     = plainLo;
      req.eqHi     = plainHi;
      req.eqBorder = 1'b1;
    end else if (!topHas && !leftHas) begin
      decided     = strobe.newLabel;
      req.wantNew = pixValid;
    end else if (!topHas || !leftHas) begin
      decided = topHas ? topL : leftL;
    end else if (topL == leftL) begin
      decided = topL;
    end else begin
      decided    = minL;
      req.wantEq = pixValid;
      req.eqLo   = minL;
      req.eqHi   = maxL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outLabel <= '0;
      leftReg  <= '0;
      eqValid  <= 1'b0;
      eqLo     <= '0;
      eqHi     <= '0;
      eqBorder <= 1'b0;
    end else begin
      outValid <= pixValid;
      eqValid  <= strobe.eqGrant;
      if (pixValid) begin
        outLabel <= decided;
        leftReg  <= decided;
        eqLo     <= req.eqLo;
        eqHi     <= req.eqHi;
        eqBorder <= req.eqBorder;
      end
    end
  end
endmodule

// File: rtl/cc_first_pass.sv
module cc_first_pass
  import ccl_pkg::*;
#(
  parameter int MAX_COLS   = 512,
  parameter int MAX_LABELS = 254,
  parameter int MAX_EQUIV  = 512,
  localparam int COL_W = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1,
  localparam int EQ_W  = $clog2(MAX_EQUIV + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             borderEn,
  input  logic             pixValid,
  input  logic             pixData,
  input  logic             pixSof,
  input  logic             pixEol,
  input  logic             pixEof,
  output logic             outValid,
  output logic [LBL_W-1:0] outLabel,
  output logic             eqValid,
  output logic [LBL_W-1:0] eqLo,
  output logic [LBL_W-1:0] eqHi,
  output logic             eqBorder,
  output logic             doneValid,
  output logic [LBL_W-1:0] labelsUsed,
  output logic [EQ_W-1:0]  equivsUsed,
  output logic             frameOverflow
);
  ctrl2dp_t         strobe;
  dp2ctrl_t         req;
  logic [COL_W-1:0] col;

  ccl_ctrl #(.MAX_COLS(MAX_COLS), .MAX_LABELS(MAX_LABELS), .MAX_EQUIV(MAX_EQUIV)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .pixValid      (pixValid),
    .pixSof        (pixSof),
    .pixEol        (pixEol),
    .pixEof        (pixEof),
    .req           (req),
    .strobe        (strobe),
    .col           (col),
    .doneValid     (doneValid),
    .labelsUsed    (labelsUsed),
    .equivsUsed    (equivsUsed),
    .frameOverflow (frameOverflow)
  );

  ccl_datapath #(.MAX_COLS(MAX_COLS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .borderEn (borderEn),
    .pixValid (pixValid),
    .pixData  (pixData),
    .pixEol   (pixEol),
    .col      (col),
    .strobe   (strobe),
    .req      (req),
    .outValid (outValid),
    .outLabel (outLabel),
    .eqValid  (eqValid),
    .eqLo     (eqLo),
    .eqHi     (eqHi),
    .eqBorder (eqBorder)
  );
endmodule

// File: rtl/cc_first_pass_chk.sv
module cc_first_pass_chk
  import ccl_pkg::*;
#(
  parameter int MAX_LABELS = 254,
  parameter int MAX_EQUIV  = 512,
  localparam int EQ_W = $clog2(MAX_EQUIV + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             borderEn,
  input logic             pixValid,
  input logic             pixData,
  input logic             pixSof,
  input logic             pixEof,
  input logic             outValid,
  input logic [LBL_W-1:0] outLabel,
  input logic             eqValid,
  input logic [LBL_W-1:0] eqLo,
  input logic [LBL_W-1:0] eqHi,
  input logic             eqBorder,
  input logic             doneValid,
  input logic [LBL_W-1:0] labelsUsed,
  input logic [EQ_W-1:0]  equivsUsed
);
  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (outValid == $past(pixValid)));

  // R1
  background_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !pixData) |=> (outLabel == '0 && !eqValid));

  // R6
  label_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    labelsUsed <= LBL_W'(MAX_LABELS));

  // R7
  equiv_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    equivsUsed <= EQ_W'(MAX_EQUIV));

  // R4
  merge_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eqValid && !eqBorder) |-> (eqLo < eqHi && outLabel == eqLo && eqLo != '0));

  // R10
  border_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLabel == BORDER_LBL) |-> $past(borderEn));

  // R9
  done_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(pixValid && pixEof));

  // R5
  no_repeat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eqValid && $past(eqValid) && !$past(pixValid && pixSof))
      |-> !(eqLo == $past(eqLo) && eqHi == $past(eqHi) && eqBorder == $past(eqBorder)));
endmodule

bind cc_first_pass cc_first_pass_chk #(.MAX_LABELS(MAX_LABELS), .MAX_EQUIV(MAX_EQUIV)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .borderEn   (borderEn),
  .pixValid   (pixValid),
  .pixData    (pixData),
  .pixSof     (pixSof),
  .pixEof     (pixEof),
  .outValid   (outValid),
  .outLabel   (outLabel),
  .eqValid    (eqValid),
  .eqLo       (eqLo),
  .eqHi       (eqHi),
  .eqBorder   (eqBorder),
  .doneValid  (doneValid),
  .labelsUsed (labelsUsed),
  .equivsUsed (equivsUsed)
);

// File: tb/cc_first_pass_bench.sv
module cc_first_pass_bench;
  localparam int MAXC = 8;
  localparam int MAXL = 5;
  localparam int MAXE = 3;
  localparam int EQW  = $clog2(MAXE + 1);
  localparam int BRD  = 255;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic borderEn = 1'b0, pixValid = 1'b0, pixData = 1'b0;
  logic pixSof = 1'b0, pixEol = 1'b0, pixEof = 1'b0;
  logic outValid, eqValid, eqBorder, doneValid, frameOverflow;
  logic [7:0] outLabel, eqLo, eqHi, labelsUsed;
  logic [EQW-1:0] equivsUsed;

  always #2 clk = ~clk;

  cc_first_pass #(.MAX_COLS(MAXC), .MAX_LABELS(MAXL), .MAX_EQUIV(MAXE)) u_cc_first_pass (
    .clk(clk), .rstN(rstN), .borderEn(borderEn), .pixValid(pixValid), .pixData(pixData),
    .pixSof(pixSof), .pixEol(pixEol), .pixEof(pixEof), .outValid(outValid),
    .outLabel(outLabel), .eqValid(eqValid), .eqLo(eqLo), .eqHi(eqHi), .eqBorder(eqBorder),
    .doneValid(doneValid), .labelsUsed(labelsUsed), .equivsUsed(equivsUsed),
    .frameOverflow(frameOverflow)
  );

  int checks = 0;
  int fails = 0;
  bit [31:0] seed = 32'h1234_5678;

  bit img [6][8];
  int expLab [48];
  bit expEqV [48];
  int expLo [48], expHi [48];
  bit expEqB [48];
  string labTag [48];
  string eqTag [48];
  int expCnt, expEqc;
  bit expOvf;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int nextRnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return int'(seed & 32'h7fff_ffff);
  endfunction

  // expected labels built directly from the requirement rules
  task automatic modelFrame(input int w, input int h, input bit bEn);
    int lab [6][8];
    int cnt = 0, eqc = 0, pl = 0, ph = 0;
    bit ovf = 0, lv = 0, pb = 0;
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c++) begin
        int i = r * w + c;
        int top = (r == 0) ? 0 : lab[r-1][c];
        int left = (c == 0) ? 0 : lab[r][c-1];
        int lo = 0, hi = 0, L = 0;
        bit want = 0, eb = 0;
        eqTag[i] = "R1";
        if (!img[r][c]) begin
          L = 0; labTag[i] = "R1";
        end else if (bEn && (r == 0 || c == 0 || c == w - 1 || top == BRD || left == BRD)) begin
          bit tn = (top != 0 && top != BRD);
          bit ln = (left != 0 && left != BRD);
          L = BRD; labTag[i] = "R10"; eqTag[i] = "R10";
          if (tn || ln) begin
            want = 1; eb = 1;
            if (tn && ln) begin lo = (top < left) ? top : left; hi = (top < left) ? left : top; end
            else begin lo = tn ? top : left; hi = lo; end
          end
        end else if (top == 0 && left == 0) begin
          if (cnt >= MAXL) begin L = MAXL; ovf = 1; labTag[i] = "R6"; end
          else begin cnt++; L = cnt; labTag[i] = "R2"; end
        end else if (top == 0 || left == 0 || top == left) begin
          L = (top != 0) ? top : left; labTag[i] = "R3";
        end else begin
          lo = (top < left) ? top : left; hi = (top < left) ? left : top;
          L = lo; want = 1; labTag[i] = "R4"; eqTag[i] = "R4";
        end
        expEqV[i] = 0; expLo[i] = lo; expHi[i] = hi; expEqB[i] = eb;
        if (want) begin
          if (lv && pl == lo && ph == hi && pb == eb) eqTag[i] = "R5";
          else if (eqc >= MAXE) begin ovf = 1; eqTag[i] = "R7"; end
          else begin expEqV[i] = 1; eqc++; lv = 1; pl = lo; ph = hi; pb = eb; end
        end
        lab[r][c] = L;
        expLab[i] = L;
      end
    end
    expCnt = cnt; expEqc = eqc; expOvf = ovf;
  endtask

  task automatic idleCycle();
    pixValid = 0; pixData = 0; pixSof = 0; pixEol = 0; pixEof = 0;
    @(negedge clk);
    chk("R11", "outValid on idle", int'(outValid), 0);
    chk("R11", "eqValid on idle", int'(eqValid), 0);
  endtask

  task automatic runFrame(input int w, input int h, input bit bEn, input bit gaps);
    modelFrame(w, h, bEn);
    borderEn = bEn;
    for (int i = 0; i < w * h; i++) begin
      if (gaps && (nextRnd() % 4 == 0)) idleCycle();
      pixValid = 1;
      pixData = img[i / w][i % w];
      pixSof = (i == 0);
      pixEol = ((i % w) == w - 1);
      pixEof = (i == w * h - 1);
      @(negedge clk);
      chk("R11", "outValid", int'(outValid), 1);
      chk(labTag[i], "label", int'(outLabel), expLab[i]);
      chk(eqTag[i], "eqValid", int'(eqValid), int'(expEqV[i]));
      if (expEqV[i]) begin
        chk(eqTag[i], "eqLo", int'(eqLo), expLo[i]);
        chk(eqTag[i], "eqHi", int'(eqHi), expHi[i]);
        chk(eqTag[i], "eqBorder", int'(eqBorder), int'(expEqB[i]));
      end
      chk("R9", "doneValid", int'(doneValid), int'(i == w * h - 1));
      if (i == w * h - 1) begin
        chk("R8", "labelsUsed", int'(labelsUsed), expCnt);
        chk("R8", "equivsUsed", int'(equivsUsed), expEqc);
        chk("R8", "frameOverflow", int'(frameOverflow), int'(expOvf));
      end
    end
    idleCycle();
    chk("R9", "done after frame", int'(doneValid), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12", "outValid", int'(outValid), 0);
    chk("R12", "eqValid", int'(eqValid), 0);
    chk("R12", "doneValid", int'(doneValid), 0);
    chk("R12", "labelsUsed", int'(labelsUsed), 0);
    chk("R12", "equivsUsed", int'(equivsUsed), 0);
    chk("R12", "frameOverflow", int'(frameOverflow), 0);

    // every 4x3 image, plain then edge-tagging mode
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 4096; p++) begin
        for (int k = 0; k < 12; k++) img[k / 4][k % 4] = p[k];
        runFrame(4, 3, m[0], 1'b0);
      end
    end

    // denser random 8x6 frames with idle gaps, both modes
    for (int f = 0; f < 150; f++) begin
      for (int k = 0; k < 48; k++) img[k / 8][k % 8] = (nextRnd() % 3) != 0;
      runFrame(8, 6, f[0], 1'b1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule